// File: doc/BRIEF.md
# UDP Register Request/Reply Engine

This block takes the payload of one register-access datagram as a byte stream and returns the reply payload as a byte stream. Ethernet, IP and UDP framing are handled elsewhere. The first eight bytes are an opaque tag that the reply repeats. Each later eight-byte record asks for one 32-bit register read or write. The reply has the same length as the request and the same record layout. Read records come back carrying the register value. Write records come back unchanged.

The request is first captured whole into an internal record store, and its length is checked once the final byte arrives. A payload with too few or too many whole records is rejected: a one-cycle drop pulse is raised, no bus access is made and no reply byte is sent. An accepted payload is then replayed record by record. Each record performs its register access on a simple synchronous bus and is then streamed out. Input is held off from the last accepted byte until the final reply byte has been taken.

Top module: `udprr_top`

## Requirements
- R1: The first 8 payload bytes are repeated unchanged as the first 8 reply bytes.
- R2: Each record is flags byte, 24-bit word address (most significant byte first), 32-bit data (most significant byte first). The flags byte is echoed unchanged. Only flag bit 4 (mask 0x10) is decoded; the other seven bits do not alter the operation.
- R3: A record whose flag bit 4 is clear raises bus_we for one cycle, with bus_addr holding the record's address and bus_wdata holding its data. Its data is echoed unchanged.
- R4: A record whose flag bit 4 is set raises bus_re for one cycle with its address. The reply data field is the bus_rdata value from the following cycle. The request's data field is ignored.
- R5: Records execute strictly in arrival order, at most one bus access per cycle, so a read that follows a write to the same address in one payload returns the written value.
- R6: Bytes after the last whole multiple of 8 are discarded, and the reply length is that multiple.
- R7: A payload with fewer than 4 or more than 128 whole 8-byte units (header included) raises drop for one cycle, performs no bus access and produces no reply byte.
- R8: in_ready is low while any reply byte is pending.
- R9: The reply uses valid/ready. out_data holds steady while out_valid is high and out_ready is low, and out_last is high only on the final reply byte.
- R10: After reset, in_ready is high and out_valid, drop, bus_we and bus_re are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request byte valid |
| in_data | input | 8 | Request byte |
| in_last | input | 1 | Final byte of the request payload |
| in_ready | output | 1 | Engine accepts a request byte |
| out_valid | output | 1 | Reply byte valid |
| out_data | output | 8 | Reply byte |
| out_last | output | 1 | Final byte of the reply |
| out_ready | input | 1 | Downstream takes the reply byte |
| drop | output | 1 | One-cycle pulse on a rejected payload |
| bus_we | output | 1 | Register write strobe |
| bus_re | output | 1 | Register read strobe |
| bus_addr | output | 24 | Register word address |
| bus_wdata | output | 32 | Register write data |
| bus_rdata | input | 32 | Register read data, valid one cycle after bus_re |

## Verification
The drop pulse is due in the cycle right after the edge that takes the last request byte. The first reply byte is due two cycles after that edge. The bench model of the register file answers bus_re on the next edge, so read data is in place one cycle after the strobe, which is how R4 defines it. Every output is sampled one time unit after a falling edge, when the registers and the combinational outputs are settled. Each reply byte is counted only in the cycle where valid and ready are both high, so the comparison against the bench-computed reply does not depend on the random stalls on out_ready or the gaps in the input.

// File: rtl/udprr_pkg.sv
package udprr_pkg;
  localparam int BYTE_W = 8;
  localparam int UNIT_W = 64;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int RD_BIT = 60;  // flag bit 4 of the leading byte

  typedef enum logic [1:0] {TX_IDLE, TX_LOAD, TX_WAIT, TX_SEND} tx_st_e;
endpackage

// File: rtl/udprr_store.sv
module udprr_store import udprr_pkg::*; #(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [UNIT_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [UNIT_W-1:0] rd_word
);
  logic [UNIT_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_word;
  end

  assign rd_word = mem_q[rd_idx];
endmodule

// File: rtl/udprr_rx.sv
module udprr_rx import udprr_pkg::*; #(
  parameter int DEPTH = 128,
  parameter int MIN_UNITS = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH * 8) + 1,
  localparam int UCNT_W = CNT_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              tx_done,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [UNIT_W-1:0] wr_word,
  output logic              start,
  output logic [IDX_W-1:0]  last_idx,
  output logic              drop
);
  logic              hold_q, hold_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic [UNIT_W-1:0] sh_q, sh_d;
  logic              start_q, start_d, drop_q, drop_d;
  logic [IDX_W-1:0]  lidx_q, lidx_d;
  logic [UCNT_W-1:0] units;
  logic              acc, len_ok;

  assign in_ready = !hold_q;
  assign acc      = in_valid && in_ready;
  assign cnt_inc  = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(1);
  assign units    = cnt_inc[CNT_W-1:3];
  assign len_ok   = (units >= UCNT_W'(MIN_UNITS)) && (units <= UCNT_W'(DEPTH));
  assign wr_word  = {sh_q[UNIT_W-BYTE_W-1:0], in_data};
  assign wr_idx   = cnt_q[3 +: IDX_W];
  assign wr_en    = acc && (cnt_q[2:0] == 3'd7) && (cnt_q[CNT_W-1:3] < UCNT_W'(DEPTH));

  always_comb begin
    hold_d  = hold_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    lidx_d  = lidx_q;
    start_d = 1'b0;
    drop_d  = 1'b0;
    if (acc) begin
      sh_d = wr_word;
      if (in_last) begin
        cnt_d = '0;
        if (len_ok) begin
          hold_d  = 1'b1;
          start_d = 1'b1;
          lidx_d  = IDX_W'(units - UCNT_W'(1));
        end else begin
          drop_d = 1'b1;
        end
      end else begin
        cnt_d = cnt_inc;
      end
    end
    if (hold_q && tx_done) hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      lidx_q  <= '0;
      start_q <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      lidx_q  <= lidx_d;
      start_q <= start_d;
      drop_q  <= drop_d;
    end
  end

  assign start    = start_q;
  assign drop     = drop_q;
  assign last_idx = lidx_q;
endmodule

// File: rtl/udprr_tx.sv
module udprr_tx import udprr_pkg::*; #(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  last_idx,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [UNIT_W-1:0] rd_word,
  output logic              bus_we,
  output logic              bus_re,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  input  logic              out_ready,
  output logic              done
);
  tx_st_e            st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d, lst_q, lst_d;
  logic [2:0]        b_q, b_d;
  logic [UNIT_W-1:0] word_q, word_d;
  logic              is_hdr, is_rd, fire;

  assign is_hdr    = (idx_q == '0);
  assign is_rd     = rd_word[RD_BIT];
  assign rd_idx    = idx_q;
  assign bus_addr  = rd_word[DATA_W +: ADDR_W];
  assign bus_wdata = rd_word[DATA_W-1:0];
  assign bus_we    = (st_q == TX_LOAD) && !is_hdr && !is_rd;
  assign bus_re    = (st_q == TX_LOAD) && !is_hdr && is_rd;
  assign out_valid = (st_q == TX_SEND);
  assign out_data  = word_q[UNIT_W-1 -: BYTE_W];
  assign out_last  = out_valid && (idx_q == lst_q) && (b_q == 3'd7);
  assign fire      = out_valid && out_ready;
  assign done      = fire && out_last;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    lst_d  = lst_q;
    b_d    = b_q;
    word_d = word_q;
    case (st_q)
      TX_IDLE: if (start) begin
        idx_d = '0;
        lst_d = last_idx;
        st_d  = TX_LOAD;
      end
      TX_LOAD: begin
        word_d = rd_word;
        b_d    = '0;
        st_d   = (!is_hdr && is_rd) ? TX_WAIT : TX_SEND;
      end
      TX_WAIT: begin
        word_d[DATA_W-1:0] = bus_rdata;
        st_d = TX_SEND;
      end
      default: if (fire) begin
        word_d = {word_q[UNIT_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
        b_d    = b_q + 3'd1;
        if (b_q == 3'd7) begin
          if (idx_q == lst_q) begin
            st_d = TX_IDLE;
          end else begin
            idx_d = idx_q + IDX_W'(1);
            st_d  = TX_LOAD;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      idx_q  <= '0;
      lst_q  <= '0;
      b_q    <= '0;
      word_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      lst_q  <= lst_d;
      b_q    <= b_d;
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/udprr_top.sv
module udprr_top import udprr_pkg::*; #(
  parameter int MAX_RECS = 127,
  parameter int MIN_RECS = 3,
  localparam int DEPTH = MAX_RECS + 1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  input  logic              out_ready,
  output logic              drop,
  output logic              bus_we,
  output logic              bus_re,
  output logic [23:0]       bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata
);
  logic              wr_en, start, tx_done;
  logic [IDX_W-1:0]  wr_idx, rd_idx, last_idx;
  logic [UNIT_W-1:0] wr_word, rd_word;

  udprr_rx #(.DEPTH(DEPTH), .MIN_UNITS(MIN_RECS + 1)) i_rx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .tx_done(tx_done),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
    .start(start), .last_idx(last_idx), .drop(drop)
  );

  udprr_store #(.DEPTH(DEPTH)) i_store (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );

  udprr_tx #(.DEPTH(DEPTH)) i_tx (
    .clk(clk), .rst_n(rst_n),
    .start(start), .last_idx(last_idx),
    .rd_idx(rd_idx), .rd_word(rd_word),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .done(tx_done)
  );
endmodule

// File: rtl/udprr_chk.sv
module udprr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       out_ready,
  input logic       drop,
  input logic       bus_we,
  input logic       bus_re
);
  assert_one_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  assert_no_reply_on_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (!out_valid && !bus_we && !bus_re));

  assert_input_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_last_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_drop_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !drop);
endmodule

bind udprr_top udprr_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
  .drop(drop), .bus_we(bus_we), .bus_re(bus_re)
);

// File: tb/test_udprr_top.sv
`timescale 1ns/1ps
module test_udprr_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_last, out_ready;
  logic [7:0]  in_data;
  logic        in_ready, out_valid, out_last, drop, bus_we, bus_re;
  logic [7:0]  out_data;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #2 clk = ~clk;  // 250 MHz

  udprr_top i_udprr_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .drop(drop), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // register file model: one-cycle read latency, low 6 address bits decoded
  logic [31:0] dev [64];
  logic [31:0] emem [64];
  always @(posedge clk) begin
    if (bus_we) dev[bus_addr[5:0]] <= bus_wdata;
    if (bus_re) bus_rdata <= dev[bus_addr[5:0]];
  end

  int checks = 0, fails = 0;
  logic [7:0] msg [0:1039];
  logic [7:0] expv [0:1039];
  logic [7:0] got [0:1039];
  int exp_n, gn, last_pos, busops, stall_err, stab_err;
  bit exp_ok, got_last, got_drop, rdy_rand;
  logic [23:0] last_wa;
  logic [31:0] last_wd;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expd);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expd);
    end
  endtask

  // monitor
  initial begin
    bit pv, pr;
    logic [7:0] pd;
    pv = 0; pr = 0; pd = 0;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
      #1;
      if (rst_n) begin
        if (out_valid && in_ready) stall_err++;
        if (pv && !pr && (!out_valid || out_data != pd)) stab_err++;
        if (bus_we || bus_re) busops++;
        if (bus_we) begin last_wa = bus_addr; last_wd = bus_wdata; end
        if (drop) got_drop = 1;
        if (out_valid && out_ready) begin
          got[gn] = out_data;
          if (out_last) begin got_last = 1; last_pos = gn; end
          gn++;
        end
      end
      pv = out_valid; pr = out_ready; pd = out_data;
    end
  end

  function automatic logic [31:0] initval(input int i);
    return 32'hA500_0000 + i * 32'h0101_0101;
  endfunction

  task automatic build_exp(input int n);
    int units;
    units = n / 8;
    exp_ok = (units >= 4) && (units <= 128);
    exp_n = exp_ok ? units * 8 : 0;
    if (exp_ok) begin
      for (int i = 0; i < exp_n; i++) expv[i] = msg[i];
      for (int r = 1; r < units; r++) begin
        logic [5:0] a;
        a = msg[8*r+3][5:0];
        if (msg[8*r][4]) begin
          {expv[8*r+4], expv[8*r+5], expv[8*r+6], expv[8*r+7]} = emem[a];
        end else begin
          emem[a] = {msg[8*r+4], msg[8*r+5], msg[8*r+6], msg[8*r+7]};
        end
      end
    end
  endtask

  task automatic run_msg(input int n, input bit gaps, input string name);
    int mism, fb_a, fb_e, lim;
    build_exp(n);
    gn = 0; got_last = 0; got_drop = 0; busops = 0; stall_err = 0; stab_err = 0; last_pos = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gaps && ($urandom % 5) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1; in_data = msg[i]; in_last = (i == n - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    lim = 0;
    while (!got_last && !got_drop && lim < 20000) begin @(negedge clk); lim++; end
    repeat (4) @(negedge clk);
    #2;
    chk(got_drop == !exp_ok, {name, " R7 drop pulse"}, got_drop, !exp_ok);
    chk(gn == exp_n, {name, " R6 reply length"}, gn, exp_n);
    if (exp_ok) begin
      mism = 0; fb_a = 0; fb_e = 0;
      for (int i = 8; i < exp_n && i < gn; i++)
        if (got[i] !== expv[i]) begin
          if (mism == 0) begin fb_a = got[i]; fb_e = expv[i]; end
          mism++;
        end
      chk(mism == 0, {name, " R2/R4 record bytes"}, fb_a, fb_e);
      mism = 0;
      for (int i = 0; i < 8 && i < gn; i++) if (got[i] !== expv[i]) mism++;
      chk(mism == 0, {name, " R1 header echo"}, mism, 0);
      chk(last_pos == exp_n - 1, {name, " R9 last flag"}, last_pos, exp_n - 1);
      chk(stall_err == 0, {name, " R8 input held"}, stall_err, 0);
      chk(stab_err == 0, {name, " R9 stalled byte stable"}, stab_err, 0);
    end else begin
      chk(busops == 0, {name, " R7 no bus access"}, busops, 0);
    end
  endtask

  task automatic put_rec(input int r, input logic [7:0] f, input logic [23:0] a, input logic [31:0] d);
    {msg[8*r], msg[8*r+1], msg[8*r+2], msg[8*r+3]} = {f, a};
    {msg[8*r+4], msg[8*r+5], msg[8*r+6], msg[8*r+7]} = d;
  endtask

  task automatic rand_msg(input int units, input int extra);
    for (int i = 0; i < 8; i++) msg[i] = 8'($urandom);
    for (int r = 1; r < units; r++)
      put_rec(r, {3'($urandom), 1'($urandom), 4'($urandom)},
              {16'($urandom), 5'd0, 3'($urandom)}, $urandom);
    for (int i = 0; i < extra; i++) msg[units*8 + i] = 8'($urandom);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) begin dev[i] = initval(i); emem[i] = initval(i); end
    rdy_rand = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready && !out_valid && !drop && !bus_we && !bus_re, "R10 reset state",
        {in_ready, out_valid, drop, bus_we, bus_re}, 5'b10000);
    rst_n = 1'b1;

    // directed: read, write, read-back, odd flag bits
    {msg[0], msg[1], msg[2], msg[3], msg[4], msg[5], msg[6], msg[7]} = 64'h0123_4567_89ab_cdef;
    put_rec(1, 8'h10, 24'h000000, 32'hffff_ffff);
    put_rec(2, 8'h00, 24'h010005, 32'h1234_5678);
    put_rec(3, 8'h10, 24'h010005, 32'h0);
    put_rec(4, 8'hef, 24'h000007, 32'hcafe_f00d);
    put_rec(5, 8'hff, 24'h000007, 32'h5555_5555);
    run_msg(48, 0, "directed");
    chk(last_wa == 24'h000007 && last_wd == 32'hcafe_f00d, "R3 write address/data on bus",
        {last_wa, last_wd}, {24'h000007, 32'hcafe_f00d});
    chk({got[28], got[29], got[30], got[31]} == 32'h1234_5678, "R5 read after write",
        {got[28], got[29], got[30], got[31]}, 32'h1234_5678);

    rdy_rand = 1;
    // truncation: 35 bytes gives a 32-byte reply
    rand_msg(4, 3);
    run_msg(35, 1, "trunc");
    // too short: 31 bytes with a write that must not happen
    rand_msg(4, 0); put_rec(1, 8'h00, 24'h000002, 32'hdead_beef);
    run_msg(31, 0, "short");
    // follow-up read of that address sees the old value
    rand_msg(4, 0); put_rec(1, 8'h10, 24'h000002, 32'h0);
    run_msg(32, 0, "after-short");
    // maximum accepted, with tail bytes
    rand_msg(128, 5);
    run_msg(1029, 1, "max");
    // one unit too many
    rand_msg(129, 0);
    run_msg(1032, 0, "over");
    // random mix
    for (int k = 0; k < 20; k++) begin
      int u, e;
      u = 4 + int'($urandom % 37);
      e = int'($urandom % 8);
      rand_msg(u, e);
      run_msg(u * 8 + e, 1, "random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule